// File: doc/BRIEF.md
# DDR IQ Receive Deinterleaver

This block sits directly behind the pins of an analog-to-digital converter that interleaves two channels on a single 14-bit double-data-rate bus. The converter supplies its own source-synchronous data clock. The word present at a rising edge of that clock is the in-phase sample, and the word present at the following falling edge is the quadrature sample. Both words are two's complement. The converter also drives a single over-range line, and that line is double-pumped in the same way as the data.

The block registers the bus on both clock edges and never samples it combinationally, because the data may be skewed by about a nanosecond against the clock. It then moves the falling-edge word back into the rising-edge domain. Each in-phase sample and the quadrature sample that followed it leave the block together on one rising edge, along with a merged over-range flag and a valid strobe. Downstream logic therefore sees one complete I/Q pair per data-clock cycle, all in a single clock domain. It can filter the pairs or carry them across to another clock from there.

Top module: `adc_iq_ddr_rx`

## Requirements
- R1: The word sampled on rising edge k is presented on `i_out`, and the word sampled on the falling edge that follows it is presented on `q_out`. Both update together on rising edge k+1, so a falling-edge word is never paired with the rising-edge word that comes after it.
- R2: Both words pass through bit for bit, with no sign change, truncation or swap. This includes the most positive code 14'h1FFF, the most negative code 14'h2000, and minus one, 14'h3FFF.
- R3: `ovr_out` is the OR of the over-range line as sampled on the rising edge and on the falling edge of the same pair.
- R4: `rst` is active high and synchronous to the rising edge of `dco_clk`. While it is asserted, and until the first valid pair, `i_out`, `q_out`, `ovr_out` and `pair_vld` are all 0.
- R5: Let e1 be the first rising edge that samples `rst` low. `pair_vld` stays 0 after e1 and goes to 1 on the next rising edge (a two-cycle fill). It then stays at 1, one pair per cycle, until reset is asserted again.
- R6: Pairs come out in the order they were presented, exactly one per data-clock cycle, with none dropped or repeated, including across a reset in the middle of a stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dco_clk | input | 1 | Source-synchronous data clock from the converter |
| rst | input | 1 | Synchronous active-high reset, rising-edge domain |
| adc_d | input | 14 | DDR data bus: I before the rising edge, Q before the falling edge |
| adc_ovr | input | 1 | Over-range line, double-pumped like the data |
| i_out | output | 14 | In-phase sample of the current pair, two's complement |
| q_out | output | 14 | Quadrature sample of the current pair, two's complement |
| ovr_out | output | 1 | Over-range seen on either half of the current pair |
| pair_vld | output | 1 | High while `i_out`/`q_out` hold a valid pair |

## Verification
The bench goes after the pairing direction first. It drives a different word on each half-cycle, so a design that joined Q with the next I would show every quadrature value one pair late. It drives the extreme codes and minus one, which catch a dropped or inverted sign bit or a swapped channel. It drives the over-range line high on one edge only, so a design that looked at just one edge would lose the flag. It also checks the exact cycle in which the valid strobe appears after both the first reset and a reset in the middle of the stream. A design with a one-cycle-short or one-cycle-long fill, or one that let stale words through after reset, would produce an early, late or extra pair.

// File: rtl/iq_rx_pkg.sv
package iq_rx_pkg;

  localparam int unsigned ADC_W = 14;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } cap_edge_e;

endpackage

// File: rtl/ddr_edge_capture.sv
module ddr_edge_capture #(
  parameter int unsigned          W    = iq_rx_pkg::ADC_W,
  parameter iq_rx_pkg::cap_edge_e EDGE = iq_rx_pkg::EDGE_RISE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_d,
  input  logic         pin_ovr,
  output logic [W-1:0] cap_d,
  output logic         cap_ovr
);

  generate
    if (EDGE == iq_rx_pkg::EDGE_RISE) begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) begin
          cap_d   <= '0;
          cap_ovr <= 1'b0;
        end else begin
          cap_d   <= pin_d;
          cap_ovr <= pin_ovr;
        end
      end
    end else begin : g_fall
      always_ff @(negedge clk) begin
        if (rst) begin
          cap_d   <= '0;
          cap_ovr <= 1'b0;
        end else begin
          cap_d   <= pin_d;
          cap_ovr <= pin_ovr;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/iq_fill_track.sv
module iq_fill_track (
  input  logic clk,
  input  logic rst,
  input  logic pair_vld,
  output logic load_ok
);

  always_ff @(posedge clk) begin
    if (rst) load_ok <= 1'b0;
    else     load_ok <= 1'b1;
  end

  // R5: the strobe cannot appear on the edge right after reset
  p_fill_gap_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pair_vld);

  // R5: once up, the strobe stays up until the next reset
  p_vld_hold_r5: assert property (@(posedge clk) disable iff (rst)
    pair_vld |=> pair_vld);

endmodule

// File: rtl/iq_pair_align.sv
module iq_pair_align #(
  parameter int unsigned W = iq_rx_pkg::ADC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] i_in,
  input  logic [W-1:0] q_in,
  input  logic         ovr_i,
  input  logic         ovr_q,
  output logic [W-1:0] i_out,
  output logic [W-1:0] q_out,
  output logic         ovr_out,
  output logic         pair_vld
);

  always_ff @(posedge clk) begin
    if (rst || !load) begin
      i_out    <= '0;
      q_out    <= '0;
      ovr_out  <= 1'b0;
      pair_vld <= 1'b0;
    end else begin
      i_out    <= i_in;
      q_out    <= q_in;
      ovr_out  <= ovr_i | ovr_q;
      pair_vld <= 1'b1;
    end
  end

  // R4: no data leaks out while no pair is valid
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !pair_vld |-> (i_out == '0 && q_out == '0 && !ovr_out));

endmodule

// File: rtl/adc_iq_ddr_rx.sv
module adc_iq_ddr_rx #(
  parameter int unsigned DATA_W = iq_rx_pkg::ADC_W
) (
  input  logic              dco_clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] adc_d,
  input  logic              adc_ovr,
  output logic [DATA_W-1:0] i_out,
  output logic [DATA_W-1:0] q_out,
  output logic              ovr_out,
  output logic              pair_vld
);

  logic [DATA_W-1:0] rise_d, fall_d;
  logic              rise_ovr, fall_ovr;
  logic              load_ok;

  ddr_edge_capture #(.W(DATA_W), .EDGE(iq_rx_pkg::EDGE_RISE)) u_cap_rise (
    .clk(dco_clk), .rst(rst), .pin_d(adc_d), .pin_ovr(adc_ovr),
    .cap_d(rise_d), .cap_ovr(rise_ovr)
  );

  ddr_edge_capture #(.W(DATA_W), .EDGE(iq_rx_pkg::EDGE_FALL)) u_cap_fall (
    .clk(dco_clk), .rst(rst), .pin_d(adc_d), .pin_ovr(adc_ovr),
    .cap_d(fall_d), .cap_ovr(fall_ovr)
  );

  iq_fill_track u_fill (
    .clk(dco_clk), .rst(rst), .pair_vld(pair_vld), .load_ok(load_ok)
  );

  iq_pair_align #(.W(DATA_W)) u_align (
    .clk(dco_clk), .rst(rst), .load(load_ok),
    .i_in(rise_d), .q_in(fall_d), .ovr_i(rise_ovr), .ovr_q(fall_ovr),
    .i_out(i_out), .q_out(q_out), .ovr_out(ovr_out), .pair_vld(pair_vld)
  );

  // R1: I leaves two rising edges after it sat on the pins
  p_i_pairing_r1: assert property (@(posedge dco_clk) disable iff (rst)
    pair_vld |-> i_out == $past(adc_d, 2));

  // R1: Q is the falling-edge word just before the current pair's edge
  p_q_pairing_r1: assert property (@(negedge dco_clk) disable iff (rst)
    pair_vld |-> q_out == $past(adc_d));

  // R3: a rising-half over-range reaches the flag
  p_ovr_rise_r3: assert property (@(posedge dco_clk) disable iff (rst)
    (pair_vld && $past(adc_ovr, 2)) |-> ovr_out);

  // R3: a falling-half over-range reaches the flag
  p_ovr_fall_r3: assert property (@(negedge dco_clk) disable iff (rst)
    (pair_vld && $past(adc_ovr)) |-> ovr_out);

endmodule

// File: tb/test_adc_iq_ddr_rx.sv
module test_adc_iq_ddr_rx;

  localparam int    DW  = 14;
  localparam time   PER = 10;
  localparam time   QTR = PER / 4;

  typedef struct {
    logic [DW-1:0] i;
    logic [DW-1:0] q;
    logic          ovr;
  } pair_t;

  logic          dco_clk = 1'b0;
  logic          rst     = 1'b1;
  logic [DW-1:0] adc_d   = '0;
  logic          adc_ovr = 1'b0;
  logic [DW-1:0] i_out, q_out;
  logic          ovr_out, pair_vld;

  pair_t exp_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    mon_on = 1'b0;
  bit    done   = 1'b0;

  always #(PER/2) dco_clk = ~dco_clk;

  adc_iq_ddr_rx i_adc_iq_ddr_rx (
    .dco_clk(dco_clk), .rst(rst), .adc_d(adc_d), .adc_ovr(adc_ovr),
    .i_out(i_out), .q_out(q_out), .ovr_out(ovr_out), .pair_vld(pair_vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: entered and left in the slot a quarter period after a falling edge
  task automatic send_pair(input logic [DW-1:0] iv, input logic [DW-1:0] qv,
                           input logic oi, input logic oq);
    pair_t p;
    adc_d = iv; adc_ovr = oi;
    @(posedge dco_clk); #(QTR);
    adc_d = qv; adc_ovr = oq;
    @(negedge dco_clk); #(QTR);
    p.i = iv; p.q = qv; p.ovr = oi | oq;
    exp_q.push_back(p);
  endtask

  task automatic check_idle(input string req);
    chk(i_out == '0,     req, int'(i_out),    0);
    chk(q_out == '0,     req, int'(q_out),    0);
    chk(ovr_out == 1'b0, req, int'(ovr_out),  0);
    chk(pair_vld == 1'b0, req, int'(pair_vld), 0);
  endtask

  task automatic mid_reset();
    @(negedge dco_clk); #3;
    mon_on = 1'b0;
    chk(exp_q.size() == 0, "R6 drain before reset", exp_q.size(), 0);
    exp_q.delete();
    rst = 1'b1;
    repeat (2) @(posedge dco_clk);
    @(negedge dco_clk); #(QTR);
    check_idle("R4 mid-stream reset");
    rst = 1'b0;
    mon_on = 1'b1;
  endtask

  // monitor: samples one time unit after each falling edge
  initial begin
    forever begin
      @(negedge dco_clk); #1;
      if (mon_on) begin
        if (exp_q.size() == 0) begin
          chk(pair_vld == 1'b0, "R5 fill, no pair yet", int'(pair_vld), 0);
        end else begin
          pair_t e;
          e = exp_q.pop_front();
          chk(pair_vld == 1'b1, "R5/R6 pair strobe", int'(pair_vld), 1);
          chk(i_out == e.i, "R1/R2 i_out", int'(i_out), int'(e.i));
          chk(q_out == e.q, "R1/R2 q_out", int'(q_out), int'(e.q));
          chk(ovr_out == e.ovr, "R3 ovr_out", int'(ovr_out), int'(e.ovr));
        end
      end
    end
  end

  initial begin
    #(PER * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge dco_clk);
    @(negedge dco_clk); #(QTR);
    check_idle("R4 initial reset");
    rst = 1'b0;
    mon_on = 1'b1;
    // R2 extremes and sign, R1 ordering
    send_pair(14'h1FFF, 14'h2000, 1'b0, 1'b0);
    send_pair(14'h2000, 14'h1FFF, 1'b0, 1'b0);
    send_pair(14'h3FFF, 14'h0001, 1'b0, 1'b0);
    send_pair(14'h0000, 14'h0000, 1'b0, 1'b0);
    send_pair(14'h2AAA, 14'h1555, 1'b0, 1'b0);
    // R3 over-range on each half alone and both
    send_pair(14'h0123, 14'h3210, 1'b1, 1'b0);
    send_pair(14'h0456, 14'h3654, 1'b0, 1'b1);
    send_pair(14'h1FFF, 14'h1FFF, 1'b1, 1'b1);
    send_pair(14'h2000, 14'h2000, 1'b0, 1'b0);
    for (int k = 0; k < 200; k++) begin
      send_pair(DW'($urandom), DW'($urandom), 1'($urandom), 1'($urandom));
    end
    // R6 reset in the middle of a stream, then refill (R5)
    mid_reset();
    send_pair(14'h2000, 14'h1FFF, 1'b1, 1'b0);
    for (int k = 0; k < 50; k++) begin
      send_pair(DW'($urandom), DW'($urandom), 1'($urandom), 1'($urandom));
    end
    @(negedge dco_clk); #3;
    mon_on = 1'b0;
    chk(exp_q.size() == 0, "R6 every pair delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule